// File: doc/BRIEF.md
# Buffered SPI Master Data Port

This block is a byte-wide SPI master that a CPU drives through two registers on a simple single-cycle bus. The data register is at address 0. A write to it places a byte in a transmit holding buffer. The shift engine takes that byte as soon as it is free. A read of the data register returns the receive buffer, which holds the last byte accepted from the line. The status register is at address 1 and shows whether the holding buffer can take another byte, whether a received byte is waiting, whether data has been lost, whether a write was refused, and whether a transfer is in progress.

The holding buffer is separate from the shifter, so software can queue the next byte while the current one is still on the wire. When a byte is queued at the moment a transfer ends, the next transfer begins without a gap. If a byte finishes while the previous one has not yet been read, the unread byte is kept and the new one is dropped. An overrun flag records the loss. This flag can be cleared only by a status read followed by a data read.

The serial side runs SPI mode 0, most significant bit first. SCLK is low when idle, and its period is DIV system clocks.

Top module: `spi_master_port`

## Requirements
- R1: A data-register write (bus_addr=0, bus_we=1) accepted while the holding buffer is empty starts a transfer: busy (status bit 4) rises two clock edges after the write edge if the engine was idle, and SCLK first rises DIV/2 clocks after that.
- R2: Status bit 0 (holding buffer empty) is 1 after reset, goes to 0 on the edge of an accepted data write, and returns to 1 on the edge where the byte moves into the shifter.
- R3: A data-register read (bus_addr=0, bus_we=0) returns the receive buffer combinationally, and that buffer holds 0x00 after reset.
- R4: Status bit 1 (receive full) sets when a finished byte is stored in the receive buffer, and a data read clears it on that edge.
- R5: When a byte finishes while receive full is set, the receive buffer keeps its old byte, the new byte is discarded, and status bit 2 (overrun) is set.
- R6: Overrun stays set until a status read that sees it set is followed by a data read. A data read alone does not clear it.
- R7: If the holding buffer is full on the edge that ends a transfer, the next transfer starts on that same edge, and SCLK stays low for exactly DIV/2 clocks between the two bytes.
- R8: Mode 0 timing: each bit is DIV clocks long, with SCLK low for the first half and high for the second. MOSI carries bits MSB first and changes only when SCLK falls. MISO is sampled on the edge where SCLK rises. When no transfer is active, SCLK and MOSI are 0.
- R9: A data write while status bit 0 is 0 is ignored: the queued byte and the output stream are unchanged. It sets the sticky status bit 3 (write collision), which a status read clears.
- R10: Status bit 4 (busy) is 1 from the edge a transfer starts to the edge it ends. Status bits above bit 4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data register, 1 = status register |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, valid in the cycle of a read access |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench drives the port with several patterns. A single isolated byte checks the start latency and the idle line levels. Two bytes are queued back to back and left unread, which separates gapless chaining from a restart with an idle gap, and which shows whether the old byte or the new one survives an overrun. A lone data read is issued against an overrun, then a status read followed by a data read, which tells the two-step clear apart from a simple read-to-clear. A write is issued while the holding buffer is full, which shows whether the queued byte was overwritten. All-ones, all-zeros and single-bit bytes, against a changing slave pattern, expose bit order and sampling-edge errors on both lines.

// File: rtl/spi_port_pkg.sv
// Package: shared register decode constants and the status word layout for
// the buffered SPI master port. Assumes a one-bit register address.
package spi_port_pkg;

    localparam logic ADDR_DATA   = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;
    localparam int   STATUS_W    = 5;

    // Status word, least significant field last (bit 0 = holding empty).
    typedef struct packed {
        logic busy;
        logic wcol;
        logic ovr;
        logic rxf;
        logic txe;
    } status_t;

endpackage

// File: rtl/spi_sclk_timer.sv
// Module: spi_sclk_timer
// Produces the mode-0 serial clock for one active transfer. Each bit period is
// DIV system clocks: a low half followed by a high half. Pulses rise_tick on
// the last low cycle and fall_tick on the last high cycle.
// Assumes DIV is even and at least 2. restart wins over run.
module spi_sclk_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic rise_tick,
    output logic fall_tick,
    output logic sclk
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] half_cnt;
    logic          phase_hi;

    // Half-period counter and phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_cnt <= '0;
            phase_hi <= 1'b0;
        end else if (restart) begin
            half_cnt <= '0;
            phase_hi <= 1'b0;
        end else if (run) begin
            if (half_cnt == LAST) begin
                half_cnt <= '0;
                phase_hi <= ~phase_hi;
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

    // Edge strobes and the visible clock level.
    always_comb begin
        rise_tick = run && !phase_hi && (half_cnt == LAST);
        fall_tick = run &&  phase_hi && (half_cnt == LAST);
        sclk      = run && phase_hi;
    end

endmodule

// File: rtl/spi_shift_engine.sv
// Module: spi_shift_engine
// Shifts one W-bit word out on MOSI (MSB first) and in from MISO. It samples
// on the rising SCLK edge and advances on the falling edge. start loads a new
// word and may coincide with the done pulse of the previous word, which gives
// gapless chaining. Assumes start is only raised when idle or on done.
module spi_shift_engine #(
    parameter int W   = 8,
    parameter int DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] load_data,
    input  logic         miso,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx_word,
    output logic         sclk,
    output logic         mosi
);
    localparam int BCW = $clog2(W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(W - 1);

    logic [W-1:0]   tx_sh;
    logic [W-1:0]   rx_sh;
    logic [BCW-1:0] bit_cnt;
    logic           rise_tick;
    logic           fall_tick;

    spi_sclk_timer #(.DIV(DIV)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .restart   (start),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .sclk      (sclk)
    );

    // Word framing, output shifter and input sampler.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_cnt <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            tx_sh   <= load_data;
            bit_cnt <= '0;
        end else if (busy) begin
            if (rise_tick) begin
                rx_sh <= {rx_sh[W-2:0], miso};
            end
            if (fall_tick) begin
                if (bit_cnt == LAST_BIT) begin
                    busy <= 1'b0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    tx_sh   <= {tx_sh[W-2:0], 1'b0};
                end
            end
        end
    end

    // Completion strobe and line outputs.
    always_comb begin
        done    = fall_tick && (bit_cnt == LAST_BIT);
        rx_word = rx_sh;
        mosi    = busy && tx_sh[W-1];
    end

endmodule

// File: rtl/spi_port_regs.sv
// Module: spi_port_regs
// CPU-side register file: the transmit holding buffer, the receive buffer and
// the status flags with their set and clear rules. It also decides when the
// shift engine loads. Assumes one-cycle bus accesses (bus_sel pulses).
module spi_port_regs
    import spi_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_we,
    input  logic         bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         eng_busy,
    input  logic         eng_done,
    input  logic [W-1:0] eng_rx,
    output logic         load,
    output logic [W-1:0] load_data,
    output logic         st_txe,
    output logic         st_rxf,
    output logic         st_ovr,
    output logic         st_wcol,
    output logic [W-1:0] rx_hold
);
    logic [W-1:0] tx_buf;
    logic         tx_full;
    logic         ovr_armed;
    logic         wr_data;
    logic         rd_data;
    logic         rd_stat;
    status_t      status;

    // Decode bus strobes and the engine load condition.
    always_comb begin
        wr_data   = bus_sel &&  bus_we && (bus_addr == ADDR_DATA);
        rd_data   = bus_sel && !bus_we && (bus_addr == ADDR_DATA);
        rd_stat   = bus_sel && !bus_we && (bus_addr == ADDR_STATUS);
        load      = tx_full && (!eng_busy || eng_done);
        load_data = tx_buf;
        st_txe    = !tx_full;
    end

    // Transmit holding buffer: accept when empty, release on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            tx_full <= 1'b0;
        end else if (load) begin
            tx_full <= 1'b0;
        end else if (wr_data && !tx_full) begin
            tx_buf  <= bus_wdata;
            tx_full <= 1'b1;
        end
    end

    // Write-collision flag: sticky until a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                   st_wcol <= 1'b0;
        else if (wr_data && tx_full)  st_wcol <= 1'b1;
        else if (rd_stat)             st_wcol <= 1'b0;
    end

    // Receive buffer: keep the unread byte, drop a new one on overrun.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rx_hold <= '0;
        else if (eng_done && !st_rxf) rx_hold <= eng_rx;
    end

    // Receive-full flag: set by a stored byte, cleared by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n) st_rxf <= 1'b0;
        else        st_rxf <= (st_rxf && !rd_data) || (eng_done && !st_rxf);
    end

    // Overrun clear handshake: a status read seeing overrun arms the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovr_armed <= 1'b0;
        else if (rd_data)            ovr_armed <= 1'b0;
        else if (rd_stat && st_ovr)  ovr_armed <= 1'b1;
    end

    // Overrun flag: a new loss wins over a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                     st_ovr <= 1'b0;
        else if (eng_done && st_rxf)    st_ovr <= 1'b1;
        else if (rd_data && ovr_armed)  st_ovr <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        status.busy = eng_busy;
        status.wcol = st_wcol;
        status.ovr  = st_ovr;
        status.rxf  = st_rxf;
        status.txe  = st_txe;
        if (rd_data)      bus_rdata = rx_hold;
        else if (rd_stat) bus_rdata = {{(W-STATUS_W){1'b0}}, status};
        else              bus_rdata = '0;
    end

endmodule

// File: rtl/spi_master_port.sv
// Module: spi_master_port (top)
// Buffered byte-wide SPI master behind a two-register CPU port. Connects the
// register file to the shift engine. Assumes W >= 5 and an even DIV >= 2.
module spi_master_port #(
    parameter int W   = 8,
    parameter int DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_we,
    input  logic         bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         sclk,
    output logic         mosi,
    input  logic         miso
);
    logic         eng_busy;
    logic         eng_done;
    logic [W-1:0] eng_rx;
    logic         load;
    logic [W-1:0] load_data;
    logic         st_txe;
    logic         st_rxf;
    logic         st_ovr;
    logic         st_wcol;
    logic [W-1:0] rx_hold;

    spi_port_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .eng_busy  (eng_busy),
        .eng_done  (eng_done),
        .eng_rx    (eng_rx),
        .load      (load),
        .load_data (load_data),
        .st_txe    (st_txe),
        .st_rxf    (st_rxf),
        .st_ovr    (st_ovr),
        .st_wcol   (st_wcol),
        .rx_hold   (rx_hold)
    );

    spi_shift_engine #(.W(W), .DIV(DIV)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (load),
        .load_data (load_data),
        .miso      (miso),
        .busy      (eng_busy),
        .done      (eng_done),
        .rx_word   (eng_rx),
        .sclk      (sclk),
        .mosi      (mosi)
    );

endmodule

// File: rtl/spi_master_port_chk.sv
// Module: spi_master_port_chk
// Temporal properties of the port, bound into every spi_master_port instance.
module spi_master_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_sel,
    input logic         bus_we,
    input logic         bus_addr,
    input logic         sclk,
    input logic         mosi,
    input logic         busy,
    input logic         tx_empty,
    input logic         rx_full,
    input logic         ovr,
    input logic         wcol,
    input logic [W-1:0] rx_buf
);
    logic wr_d;
    logic rd_d;

    // Bus strobe decode for the properties.
    always_comb begin
        wr_d = bus_sel && bus_we && !bus_addr;
        rd_d = bus_sel && !bus_we && !bus_addr;
    end

    AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !mosi)); // R8
    AST_IDLE_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_d && tx_empty && !busy) |=> ##1 busy); // R1
    AST_TXE_CLEARS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_d && tx_empty) |=> !tx_empty); // R2
    AST_RXBUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |=> $stable(rx_buf)); // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !rd_d) |=> ovr); // R6
    AST_WCOL_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_d && !tx_empty) |=> wcol); // R9

endmodule

bind spi_master_port spi_master_port_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .sclk     (sclk),
    .mosi     (mosi),
    .busy     (eng_busy),
    .tx_empty (st_txe),
    .rx_full  (st_rxf),
    .ovr      (st_ovr),
    .wcol     (st_wcol),
    .rx_buf   (rx_hold)
);

// File: tb/spi_master_port_test.sv
`timescale 1ns/1ps
module spi_master_port_test;
    localparam int W    = 8;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_we = 1'b0;
    logic         bus_addr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         sclk;
    logic         mosi;
    logic         miso = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    spi_master_port #(.W(W), .DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // Behavioural reference state
    bit        m_busy;
    int        m_t;
    int        m_xfers;
    logic [7:0] m_out, m_in, m_rxbuf;
    logic [7:0] txq[$];
    bit        m_rxf, m_ovr, m_arm, m_wcol;

    function automatic logic [7:0] slave_byte(int k);
        return 8'h5A ^ 8'(k * 29);
    endfunction

    function automatic bit exp_sclk();
        return m_busy && ((m_t % DIV) >= HALF);
    endfunction

    function automatic bit exp_mosi();
        return m_busy && m_out[7 - m_t / DIV];
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        m_busy = 0; m_t = 0; m_xfers = 0; m_out = 0; m_in = 0; m_rxbuf = 0;
        txq.delete(); m_rxf = 0; m_ovr = 0; m_arm = 0; m_wcol = 0;
    endtask

    // Advance the reference across one rising clock edge.
    task automatic model_step(bit s, bit w, bit a, logic [7:0] d);
        bit pre_txe = (txq.size() == 0);
        bit pre_rxf = m_rxf;
        bit pre_ovr = m_ovr;
        bit pre_arm = m_arm;
        bit rd_d = s && !w && !a;
        bit rd_s = s && !w && a;
        bit done = 0;
        logic [7:0] rxb = 0;
        if (m_busy) begin
            if ((m_t % DIV) == HALF - 1) m_in = {m_in[6:0], miso};
            if (m_t == 8 * DIV - 1) begin
                done = 1; rxb = m_in; m_busy = 0;
            end else m_t++;
        end
        if (!m_busy && txq.size() > 0) begin
            m_out = txq.pop_front(); m_t = 0; m_busy = 1; m_xfers++;
        end
        if (s && w && !a) begin
            if (pre_txe) txq.push_back(d);
            else m_wcol = 1;
        end
        if (rd_s) m_wcol = 0;
        if (rd_d) m_arm = 0;
        else if (rd_s && pre_ovr) m_arm = 1;
        if (done && !pre_rxf) m_rxbuf = rxb;
        m_rxf = (pre_rxf && !rd_d) || (done && !pre_rxf);
        if (done && pre_rxf) m_ovr = 1;
        else if (rd_d && pre_arm) m_ovr = 0;
    endtask

    // One bus cycle: drive, compare every output, then step the reference.
    task automatic cyc(bit s, bit w, bit a, logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
        miso = m_busy ? slave_byte(m_xfers)[7 - m_t / DIV] : 1'b0;
        #1;
        check(sclk == exp_sclk(), "R1/R7/R8 sclk", sclk, exp_sclk());
        check(mosi == exp_mosi(), "R8 mosi", mosi, exp_mosi());
        if (s && !w && !a)
            check(bus_rdata == m_rxbuf, "R3/R5 data read", bus_rdata, m_rxbuf);
        if (s && !w && a) begin
            check(bus_rdata[0] == (txq.size() == 0), "R2 tx empty", bus_rdata[0], txq.size() == 0);
            check(bus_rdata[1] == m_rxf, "R4 rx full", bus_rdata[1], m_rxf);
            check(bus_rdata[2] == m_ovr, "R5/R6 overrun", bus_rdata[2], m_ovr);
            check(bus_rdata[3] == m_wcol, "R9 write collision", bus_rdata[3], m_wcol);
            check(bus_rdata[4] == m_busy, "R10 busy", bus_rdata[4], m_busy);
            check(bus_rdata[7:5] == 3'b000, "R10 upper bits", bus_rdata[7:5], 0);
        end
        model_step(s, w, a, d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00);
    endtask

    task automatic wr(logic [7:0] d);  cyc(1, 1, 0, d);    endtask
    task automatic rd_stat();          cyc(1, 0, 1, 8'h00); endtask
    task automatic rd_data();          cyc(1, 0, 0, 8'h00); endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state: R2 empty flag set, R3 data 0x00
        rd_stat();
        rd_data();
        // Single isolated byte: R1, R4, R8
        wr(8'h3C);
        idle(40);
        rd_stat(); rd_data(); rd_stat();
        // Queued second byte while shifting: R7, then overrun R5
        wr(8'hA1);
        idle(2);
        rd_stat();
        wr(8'h96);
        idle(80);
        rd_stat(); rd_data(); rd_stat(); rd_data(); rd_stat();
        // Data read alone leaves overrun set: R6
        wr(8'h0F); idle(2); wr(8'hF0); idle(80);
        rd_data(); rd_stat(); rd_data(); rd_stat(); rd_data(); rd_stat();
        // Write while buffer full is ignored: R9
        wr(8'h11); wr(8'h22); idle(3); wr(8'h33); wr(8'h44);
        rd_stat(); rd_stat();
        idle(80);
        rd_stat(); rd_data(); rd_stat();
        // Edge data patterns: R8
        wr(8'hFF); idle(40); rd_data();
        wr(8'h00); idle(40); rd_data();
        wr(8'h80); idle(40); rd_data();
        wr(8'h01); idle(2); wr(8'h7E); idle(3); rd_stat();
        idle(34); rd_data(); idle(40); rd_stat(); rd_data(); rd_stat();
        idle(5);
        finish_run();
    end
endmodule